// File: doc/BRIEF.md
# Cascadable Range-Selectable Binary Counter

A 4-bit synchronous up counter with a synchronous clear, a synchronous parallel load and two count enables. Counting happens only when both enables are high. A carry output flags the all-ones state, gated by only one of the two enables. That gating lets a chain of stages form a wider counter: each stage's carry feeds the carry-gating enable of the next stage.

A range selector shortens the count sequence without any other logic. A terminal-state detector forces the existing clear path or load path on the cycle when the counter would leave the chosen range. Four ranges are available: the full 0..15 cycle, 5..15, 0..10 and 3..12. A value loaded from outside the range simply counts upward, with binary wrap, until it reaches the range's terminal state.

Top module: `modcount_ctr`

## Requirements
- R1: When `sclr` is high at a rising clock edge, `count` becomes 0, whatever the other inputs are.
- R2: When `load` is high and `sclr` is low at an edge, `count` takes `load_val`. This overrides counting and the range's terminal action.
- R3: When `sclr` and `load` are low and both `cnt_en` and `chain_en` are high, `count` advances by one. With `range_sel` = 0 it wraps from 15 to 0, giving a divide-by-16 cycle.
- R4: When `sclr` and `load` are low and either `cnt_en` or `chain_en` is low, `count` holds its value.
- R5: `carry_out` is high exactly when `count` is 15 and `chain_en` is high. It does not depend on `cnt_en` or `range_sel`, and it is combinational.
- R6: With `range_sel` = 1, counting from 15 gives 5. The sequence is 5..15, then 5 again.
- R7: With `range_sel` = 2, counting from 10 gives 0. The sequence is 0..10, then 0 again.
- R8: With `range_sel` = 3, counting from 12 gives 3. The sequence is 3..12, then 3 again.
- R9: A value outside the selected range advances by one with 4-bit wrap until it meets the range's terminal state. No value is stuck.
- R10: When two stages are chained, the low stage's `carry_out` drives the high stage's `chain_en`, and `cnt_en` is high on both. The pair then counts as one 8-bit value, and the high stage steps only on the low stage's 15-to-0 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| sclr | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Synchronous parallel load |
| load_val | input | WIDTH | Value taken on load |
| cnt_en | input | 1 | Count enable that does not gate the carry |
| chain_en | input | 1 | Count enable that also gates the carry |
| range_sel | input | 2 | 0: 0..15, 1: 5..15, 2: 0..10, 3: 3..12 |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High in state 15 while `chain_en` is high |

## Verification
The assertions assume that `sclr` is pulsed at least once before any check matters. Until then the register holds an unknown value, so every property stays disabled until the first clear has been seen. They also assume that all inputs are stable around the rising edge. The bench drives every input on the falling edge, opens each run with a clear and then mixes random clears into the stimulus. Random loads cover every 4-bit value, so all ranges are entered from out-of-range states as well as in-range ones.

// File: rtl/modcount_ctr.sv
module modcount_ctr #(
  parameter int WIDTH = 4,
  parameter int LO_B  = 5,
  parameter int HI_C  = 10,
  parameter int LO_D  = 3,
  parameter int HI_D  = 12
) (
  input  logic             clk,
  input  logic             sclr,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic [1:0]       range_sel,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] B_START  = WIDTH'(LO_B);
  localparam logic [WIDTH-1:0] C_END    = WIDTH'(HI_C);
  localparam logic [WIDTH-1:0] D_START  = WIDTH'(LO_D);
  localparam logic [WIDTH-1:0] D_END    = WIDTH'(HI_D);

  logic             go;
  logic             wrap_clr;
  logic             wrap_ld;
  logic [WIDTH-1:0] wrap_val;
  logic [WIDTH-1:0] count_d;

  assign go        = cnt_en & chain_en;
  assign carry_out = chain_en & (count == ALL_ONES);

  assign wrap_clr = go & (range_sel == 2'd2) & (count == C_END);
  assign wrap_ld  = go & (((range_sel == 2'd1) & (count == ALL_ONES)) |
                          ((range_sel == 2'd3) & (count == D_END)));
  assign wrap_val = (range_sel == 2'd1) ? B_START : D_START;

  always_comb begin
    if (sclr)          count_d = '0;
    else if (load)     count_d = load_val;
    else if (wrap_clr) count_d = '0;
    else if (wrap_ld)  count_d = wrap_val;
    else if (go)       count_d = count + 1'b1;
    else               count_d = count;
  end

  always_ff @(posedge clk) count <= count_d;

  logic armed = 1'b0;
  always_ff @(posedge clk) if (sclr) armed <= 1'b1;

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    sclr |=> (count == '0));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!armed)
    (!sclr && load) |=> (count == $past(load_val)));

  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (!armed)
    (!sclr && !load && !(cnt_en && chain_en)) |=> $stable(count));

  // R3
  free_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    (!sclr && !load && cnt_en && carry_out && range_sel == 2'd0) |=> (count == '0));

  // R5
  carry_gate_chk: assert property (@(posedge clk) disable iff (!armed)
    carry_out |-> (chain_en && $countones(count) == WIDTH));

  // R6
  range_b_chk: assert property (@(posedge clk) disable iff (!armed)
    (!sclr && !load && cnt_en && carry_out && range_sel == 2'd1) |=> (count == B_START));

  // R7
  range_c_chk: assert property (@(posedge clk) disable iff (!armed)
    (!sclr && !load && go && range_sel == 2'd2 && count == C_END) |=> (count == '0));

  // R8
  range_d_chk: assert property (@(posedge clk) disable iff (!armed)
    (!sclr && !load && go && range_sel == 2'd3 && count == D_END) |=> (count == D_START));
endmodule

// File: tb/modcount_ctr_tb.sv
module modcount_ctr_tb_top;
  logic       clk = 1'b0;
  logic       sclr = 1'b0, load = 1'b0, cnt_en = 1'b0, chain_en = 1'b0;
  logic [3:0] load_val = '0;
  logic [1:0] range_sel = '0;
  logic [3:0] count;
  logic       carry_out;

  logic       c_clr = 1'b0, c_go = 1'b0;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_cy, hi_cy;

  int checks = 0, errors = 0;
  logic [3:0] model = '0;
  logic [7:0] wide = '0;
  string      tag = "R1";

  always #2 clk = ~clk;

  modcount_ctr dut_i (.clk(clk), .sclr(sclr), .load(load), .load_val(load_val),
    .cnt_en(cnt_en), .chain_en(chain_en), .range_sel(range_sel),
    .count(count), .carry_out(carry_out));

  modcount_ctr lo_i (.clk(clk), .sclr(c_clr), .load(1'b0), .load_val(4'd0),
    .cnt_en(1'b1), .chain_en(c_go), .range_sel(2'd0), .count(lo_cnt), .carry_out(lo_cy));
  modcount_ctr hi_i (.clk(clk), .sclr(c_clr), .load(1'b0), .load_val(4'd0),
    .cnt_en(1'b1), .chain_en(lo_cy), .range_sel(2'd0), .count(hi_cnt), .carry_out(hi_cy));

  function automatic logic [3:0] nxt(logic [3:0] c, logic cl, logic ld, logic [3:0] d,
                                     logic ce, logic ch, logic [1:0] r);
    if (cl) return 4'd0;
    if (ld) return d;
    if (!(ce && ch)) return c;
    case (r)
      2'd1:    return (c == 4'd15) ? 4'd5 : c + 4'd1;
      2'd2:    return (c == 4'd10) ? 4'd0 : c + 4'd1;
      2'd3:    return (c == 4'd12) ? 4'd3 : c + 4'd1;
      default: return c + 4'd1;
    endcase
  endfunction

  function automatic string rule(logic [3:0] c, logic cl, logic ld, logic ce,
                                 logic ch, logic [1:0] r);
    if (cl) return "R1";
    if (ld) return "R2";
    if (!(ce && ch)) return "R4";
    case (r)
      2'd1: return (c == 4'd15) ? "R6" : (c < 4'd5) ? "R9" : "R3";
      2'd2: return (c == 4'd10) ? "R7" : (c > 4'd10) ? "R9" : "R3";
      2'd3: return (c == 4'd12) ? "R8" : (c < 4'd3 || c > 4'd12) ? "R9" : "R3";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic step(logic cl, logic ld, logic [3:0] d, logic ce, logic ch, logic [1:0] r);
    @(negedge clk);
    check(tag, {4'd0, count}, {4'd0, model});
    sclr = cl; load = ld; load_val = d; cnt_en = ce; chain_en = ch; range_sel = r;
    #1;
    check("R5", {7'd0, carry_out}, {7'd0, (ch && model == 4'd15)});
    tag = rule(model, cl, ld, ce, ch, r);
    model = nxt(model, cl, ld, d, ce, ch, r);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    step(1, 1, 4'd9, 1, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1, 0);
    step(0, 1, 4'd15, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 14; i++) step(0, 0, 0, 1, 1, 1);
    step(0, 1, 4'd0, 1, 1, 1);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1, 1);
    step(0, 1, 4'd13, 1, 1, 2);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 1, 2);
    step(0, 1, 4'd14, 1, 1, 3);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1, 3);
    step(0, 1, 4'd12, 1, 1, 3);
    step(0, 1, 4'd7, 1, 1, 3);
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 32) == 0, ($urandom % 8) == 0, 4'($urandom),
           ($urandom % 4) != 0, ($urandom % 4) != 0,
           (i % 97 < 4) ? 2'($urandom) : range_sel);
    end
    step(0, 0, 0, 0, 0, range_sel);

    // R10 chained pair
    @(negedge clk); c_clr = 1; c_go = 0;
    @(negedge clk); c_clr = 0; wide = '0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      check("R10", {hi_cnt, lo_cnt}, wide);
      c_go = ($urandom % 5) != 0;
      if (c_go) wide = wide + 8'd1;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule